// File: doc/BRIEF.md
# SPI Receive Status and Fault Flags

This block keeps the receive-side status of an SPI peripheral: a receive-full flag, an overflow flag, a mode-fault flag and the received data byte those flags protect. The serial shift engine reports every completed byte with a one-cycle strobe. The block decides whether that byte is stored, is discarded as an overflow, or is ignored while an overflow is still pending.

Software clears flags in two steps. First it reads the status register while the flag is visible. Then it reads the data register to clear receive-full and overflow, or writes the control register to clear mode fault. Mode fault compares the synchronized slave-select level with the selected role. The role also sets the directions of the clock, MOSI and MISO pins. Receive-full, overflow and mode fault are merged into one interrupt request, with one enable for receive-full and one for the two errors.

Top module: `spi_rx_status`

## Requirements
- R1: While `rst` is high at a clock edge, `rx_full`, `overflow`, `mode_fault`, `irq` and `rx_data` go to 0, and every armed clear step is forgotten.
- R2: When `xfer_done` is high with `rx_full`=0 and `overflow`=0, the next cycle shows `rx_full`=1 and `rx_data` equal to the byte on `xfer_data`.
- R3: When `xfer_done` is high with `rx_full`=1, `overflow` becomes 1 in the next cycle. The new byte is dropped and `rx_data` keeps the older unread byte.
- R4: While `overflow`=1, a completed transfer neither sets `rx_full` nor changes `rx_data`.
- R5: `rx_full` clears on a `data_rd` pulse only if an earlier `stat_rd` pulse saw `rx_full`=1. A data read with no such status read leaves it set.
- R6: `overflow` clears on a `data_rd` pulse only if an earlier `stat_rd` pulse saw `overflow`=1.
- R7: In slave mode (`master_sel`=0), a rising edge of the synchronized `ss_pin` while `busy`=1 sets `mode_fault`. This happens three clock edges after the pin changes: two synchronizer stages plus the flag. A rising edge while `busy`=0 has no effect.
- R8: In master mode (`master_sel`=1), a low synchronized `ss_pin` sets `mode_fault`.
- R9: `mode_fault` can be set only while `fault_en`=1. Dropping `fault_en` does not clear a set `mode_fault`, but the flag stays clear after the clear sequence.
- R10: `mode_fault` clears on a `ctrl_wr` pulse only if an earlier `stat_rd` pulse saw it set. A control write with no such status read has no effect.
- R11: `sck_oe` and `mosi_oe` equal `master_sel`, and `miso_oe` is its inverse.
- R12: `irq` = (`rx_ie` AND `rx_full`) OR (`err_ie` AND (`overflow` OR `mode_fault`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1 = master role, 0 = slave role |
| fault_en | input | 1 | Mode-fault detection enable |
| rx_ie | input | 1 | Receive-full interrupt enable |
| err_ie | input | 1 | Overflow / mode-fault interrupt enable |
| ss_pin | input | 1 | Asynchronous slave-select pin level |
| busy | input | 1 | Transfer in progress |
| xfer_done | input | 1 | One-cycle transfer-complete strobe |
| xfer_data | input | 8 | Byte received by the completed transfer |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| rx_full | output | 1 | Receive-full flag |
| overflow | output | 1 | Overflow flag |
| mode_fault | output | 1 | Mode-fault flag |
| rx_data | output | 8 | Stored received byte |
| sck_oe | output | 1 | Clock pin output enable |
| mosi_oe | output | 1 | MOSI pin output enable |
| miso_oe | output | 1 | MISO pin output enable |
| irq | output | 1 | Combined receive/error interrupt request |

## Verification
Strobes that touch the flags or the data byte (completion, status read, data read, control write, enable change) show their effect one clock edge later. A change on `ss_pin` reaches `mode_fault` on the third edge. `irq` and the pin enables follow their inputs in the same cycle. The bench drives every input on the falling edge and checks flags and data at the next falling edge. For the slave-select path it checks after the second edge that the flag is still clear, and after the third that it is set. It checks `irq` and the enables a short delay after it changes an enable or the role.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;

    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    typedef struct packed {
        logic full;
        logic ovr;
        logic mfault;
    } stat_t;

    typedef struct packed {
        logic sck;
        logic mosi;
        logic miso;
    } pin_dir_t;

    function automatic pin_dir_t dir_for_role(role_e role);
        pin_dir_t d;
        d.sck  = (role == ROLE_MASTER);
        d.mosi = (role == ROLE_MASTER);
        d.miso = (role == ROLE_SLAVE);
        return d;
    endfunction

    function automatic logic irq_request(stat_t s, logic rx_en, logic err_en);
        return (rx_en & s.full) | (err_en & (s.ovr | s.mfault));
    endfunction

endpackage

// File: rtl/spi_rxs_sync.sv
module spi_rxs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sr[0] <= RST_VAL;
                else     sr[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) sr[i] <= RST_VAL;
                else     sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/spi_rxs_rxflags.sv
module spi_rxs_rxflags
    import spi_rxs_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         xfer_done,
    input  logic [W-1:0] xfer_data,
    input  logic         stat_rd,
    input  logic         data_rd,
    output logic         full,
    output logic         ovr,
    output logic [W-1:0] data
);
    logic arm_full, arm_ovr;
    logic accept, clr_full, clr_ovr;

    // A byte is taken only when nothing unread or unserviced is pending.
    assign accept   = xfer_done & ~full & ~ovr;
    assign clr_full = data_rd & arm_full;
    assign clr_ovr  = data_rd & arm_ovr;

    always_ff @(posedge clk) begin
        if (rst) begin
            full     <= 1'b0;
            ovr      <= 1'b0;
            arm_full <= 1'b0;
            arm_ovr  <= 1'b0;
            data     <= '0;
        end else begin
            if (stat_rd && full) arm_full <= 1'b1;
            else if (data_rd)    arm_full <= 1'b0;

            if (stat_rd && ovr)  arm_ovr <= 1'b1;
            else if (data_rd)    arm_ovr <= 1'b0;

            full <= (full & ~clr_full) | accept;
            ovr  <= (ovr & ~clr_ovr) | (xfer_done & full);

            if (accept) data <= xfer_data;
        end
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done && !full && !ovr |=> full && data == $past(xfer_data));
    // R3
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done && full |=> ovr);
    // R4
    data_keep_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done && (full || ovr) |=> $stable(data));
    // R4
    no_full_chk: assert property (@(posedge clk) disable iff (rst)
        ovr && !full |=> !full);
    // R5
    full_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        full && !arm_full |=> full);
    // R6
    ovr_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        ovr && !arm_ovr |=> ovr);
endmodule

// File: rtl/spi_rxs_fault.sv
module spi_rxs_fault
    import spi_rxs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ss_sync,
    input  role_e role,
    input  logic  busy,
    input  logic  fault_en,
    input  logic  stat_rd,
    input  logic  ctrl_wr,
    output logic  mfault
);
    logic ss_prev, ss_rise, bad_ss, set_fault, arm;

    assign ss_rise   = ss_sync & ~ss_prev;
    assign bad_ss    = (role == ROLE_MASTER) ? ~ss_sync : (busy & ss_rise);
    assign set_fault = fault_en & bad_ss;

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_prev <= 1'b1;
            arm     <= 1'b0;
            mfault  <= 1'b0;
        end else begin
            ss_prev <= ss_sync;
            if (stat_rd && mfault) arm <= 1'b1;
            else if (ctrl_wr)      arm <= 1'b0;
            mfault <= (mfault & ~(ctrl_wr & arm)) | set_fault;
        end
    end

    // R9
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !fault_en && !mfault |=> !mfault);
    // R10
    mf_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        mfault && !arm |=> mfault);
    // R7
    slave_idle_chk: assert property (@(posedge clk) disable iff (rst)
        role == ROLE_SLAVE && !busy && !mfault |=> !mfault);
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
    import spi_rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_sel,
    input  logic              fault_en,
    input  logic              rx_ie,
    input  logic              err_ie,
    input  logic              ss_pin,
    input  logic              busy,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              ctrl_wr,
    output logic              rx_full,
    output logic              overflow,
    output logic              mode_fault,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck_oe,
    output logic              mosi_oe,
    output logic              miso_oe,
    output logic              irq
);
    role_e    role;
    stat_t    st;
    pin_dir_t dir;
    logic     ss_s;

    assign role = master_sel ? ROLE_MASTER : ROLE_SLAVE;

    spi_rxs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(ss_pin), .q(ss_s)
    );

    spi_rxs_rxflags #(.W(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .xfer_done(xfer_done), .xfer_data(xfer_data),
        .stat_rd(stat_rd), .data_rd(data_rd),
        .full(st.full), .ovr(st.ovr), .data(rx_data)
    );

    spi_rxs_fault u_fault (
        .clk(clk), .rst(rst), .ss_sync(ss_s), .role(role), .busy(busy),
        .fault_en(fault_en), .stat_rd(stat_rd), .ctrl_wr(ctrl_wr),
        .mfault(st.mfault)
    );

    assign dir        = dir_for_role(role);
    assign sck_oe     = dir.sck;
    assign mosi_oe    = dir.mosi;
    assign miso_oe    = dir.miso;
    assign rx_full    = st.full;
    assign overflow   = st.ovr;
    assign mode_fault = st.mfault;
    assign irq        = irq_request(st, rx_ie, err_ie);

    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_full && !overflow && !mode_fault |-> !irq);
    // R11
    pin_flip_chk: assert property (@(posedge clk) disable iff (rst)
        sck_oe == mosi_oe && sck_oe != miso_oe);
endmodule

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb_top;
    logic clk = 1'b0;
    logic rst, master_sel, fault_en, rx_ie, err_ie, ss_pin, busy;
    logic xfer_done, stat_rd, data_rd, ctrl_wr;
    logic [7:0] xfer_data, rx_data;
    logic rx_full, overflow, mode_fault, sck_oe, mosi_oe, miso_oe, irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_rx_status dut_i (
        .clk(clk), .rst(rst), .master_sel(master_sel), .fault_en(fault_en),
        .rx_ie(rx_ie), .err_ie(err_ie), .ss_pin(ss_pin), .busy(busy),
        .xfer_done(xfer_done), .xfer_data(xfer_data), .stat_rd(stat_rd),
        .data_rd(data_rd), .ctrl_wr(ctrl_wr), .rx_full(rx_full),
        .overflow(overflow), .mode_fault(mode_fault), .rx_data(rx_data),
        .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe), .irq(irq)
    );

    // {done, byte[8], stat_rd, data_rd, exp_full, exp_ovr, exp_data[8]}
    localparam logic [20:0] VEC [12] = '{
        {1'b1, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5},  // R2 store
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5},  // R5 unarmed read
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5},  // R5 arm
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5},  // R5 clear
        {1'b1, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C},  // R2
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C},  // arm full only
        {1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C},  // R3 overflow, byte lost
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C},  // R6 ovr not armed
        {1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C},  // R4 blocked
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C},  // R6 arm
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C},  // R6 clear
        {1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A}   // R2 after service
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic s, input logic d, input logic c);
        stat_rd = s; data_rd = d; ctrl_wr = c;
        cyc();
        stat_rd = 0; data_rd = 0; ctrl_wr = 0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1; master_sel = 0; fault_en = 0; rx_ie = 0; err_ie = 0;
        ss_pin = 1; busy = 0; xfer_done = 0; xfer_data = 8'hFF;
        stat_rd = 0; data_rd = 0; ctrl_wr = 0;
        @(negedge clk);
        cyc(3);
        // R1 reset state
        chk("R1 rx_full", rx_full, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 mode_fault", mode_fault, 0);
        chk("R1 rx_data", rx_data, 0);
        chk("R1 irq", irq, 0);
        rst = 0;
        cyc();
        chk("R1 after release", {rx_full, overflow, mode_fault}, 0);

        for (int i = 0; i < 12; i++) begin
            xfer_done = VEC[i][20];
            xfer_data = VEC[i][19:12];
            stat_rd   = VEC[i][11];
            data_rd   = VEC[i][10];
            cyc();
            xfer_done = 0; stat_rd = 0; data_rd = 0;
            chk($sformatf("vector row %0d full", i), rx_full, VEC[i][9]);
            chk($sformatf("vector row %0d ovr", i), overflow, VEC[i][8]);
            chk($sformatf("vector row %0d data", i), rx_data, VEC[i][7:0]);
        end

        // R12 interrupt combining
        #1 chk("R12 no enables", irq, 0);
        rx_ie = 1;
        #1 chk("R12 rx_ie with full", irq, 1);
        @(negedge clk);
        xfer_done = 1; xfer_data = 8'hE1;
        cyc();
        xfer_done = 0;
        chk("R3 overflow again", overflow, 1);
        chk("R3 data kept", rx_data, 8'h5A);
        rx_ie = 0; err_ie = 1;
        #1 chk("R12 err_ie with overflow", irq, 1);
        err_ie = 0;
        #1 chk("R12 err_ie off", irq, 0);
        @(negedge clk);
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        chk("R5 R6 joint clear", {rx_full, overflow}, 0);

        // R7 slave fault on rising slave select while busy
        master_sel = 0; fault_en = 1; busy = 1; ss_pin = 0;
        cyc(4);
        chk("R7 falling select no fault", mode_fault, 0);
        ss_pin = 1;
        cyc(2);
        chk("R7 two edges still clear", mode_fault, 0);
        cyc();
        chk("R7 third edge fault", mode_fault, 1);
        err_ie = 1;
        #1 chk("R12 mode fault irq", irq, 1);
        err_ie = 0;
        @(negedge clk);
        pulse(0, 0, 1);
        chk("R10 unarmed ctrl write", mode_fault, 1);
        pulse(1, 0, 0);
        pulse(0, 0, 1);
        chk("R10 clear sequence", mode_fault, 0);
        busy = 0; ss_pin = 0;
        cyc(4);
        ss_pin = 1;
        cyc(4);
        chk("R7 rise while idle", mode_fault, 0);

        // R11 directions and R8/R9 master fault
        master_sel = 1;
        #1 chk("R11 master pins", {sck_oe, mosi_oe, miso_oe}, 3'b110);
        @(negedge clk);
        cyc(2);
        chk("R8 master select high ok", mode_fault, 0);
        fault_en = 0; ss_pin = 0;
        cyc(4);
        chk("R9 disabled no fault", mode_fault, 0);
        fault_en = 1;
        cyc();
        chk("R8 master select low", mode_fault, 1);
        fault_en = 0;
        cyc();
        chk("R9 disable keeps flag", mode_fault, 1);
        pulse(1, 0, 0);
        pulse(0, 0, 1);
        cyc(3);
        chk("R9 stays clear", mode_fault, 0);
        master_sel = 0;
        #1 chk("R11 slave pins", {sck_oe, mosi_oe, miso_oe}, 3'b001);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule